// File: doc/BRIEF.md
# Text Command Front End for a Word Memory

This block sits behind a serial byte receiver and turns typed lines of ASCII text into accesses to a 256-word by 16-bit memory. Two commands are understood: one stores a decimal value at a decimal address, and one fetches the word at an address and prints it in decimal. Each field is checked for form and range. A line that is malformed or out of range produces an error reply and leaves the memory untouched.

Bytes enter through a valid/ready handshake and replies leave through another one, so that a byte-level serial transmitter and receiver can be attached directly. While a line is being executed or answered, the input is held off through its ready signal. Two status outputs show whether the last completed line was accepted (green) or rejected (red).

Grammar of a line: a keyword, a colon, a decimal address, and for the store command a comma and a decimal value. The line ends at LF. Any CR in the line is skipped. Keywords are `write` and `read`, with letters matched in either case. Numbers may have leading zeros. Spaces and any other characters are not accepted.

Top module: `ascii_ram_cmd`

## Requirements
- R1: A line `write:<addr>,<value>` LF with addr 0..255 and value 0..65535 stores the value at addr and replies with the bytes `WR OK` CR LF.
- R2: A line `read:<addr>` LF with addr 0..255 replies with `DATA=`, then the stored word in decimal with no leading zeros (a stored 0 prints as `0`), then CR LF.
- R3: Keyword letters are matched regardless of case, so `WrItE` and `READ` are accepted.
- R4: An address above 255 makes the line an error and leaves the memory unchanged; in particular, address 256 does not alias to address 0.
- R5: A value above 65535 makes the line an error and leaves the memory unchanged. This includes digit strings of any length, which must not wrap.
- R6: A `write` line with no comma after its address is an error, and a `read` line with a comma after its address is an error.
- R7: An unknown keyword, an empty address or value field, or a character that is not a digit inside a field makes the line an error. Every error replies with `Bad Command!` CR LF. After any reply, the red output shows 1 for an error and 0 otherwise, and the green output shows the opposite. The two outputs never show 1 at the same time.
- R8: CR bytes are ignored anywhere in a line. A line is finished only by LF (0x0A), so a line ended by a bare LF is accepted.
- R9: From the cycle after a line's LF is accepted until the last reply byte has been taken, rx_ready is 0. While tx_valid is 1 and tx_ready is 0, tx_valid and tx_data hold.
- R10: After reset, both status outputs are 0, tx_valid is 0 and rx_ready is 1.
- R11: Every byte offered on tx_data is printable ASCII (0x20..0x7E), CR (0x0D) or LF (0x0A).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_data | input | 8 | Incoming ASCII byte |
| rx_valid | input | 1 | rx_data holds a byte |
| rx_ready | output | 1 | Block accepts a byte this cycle |
| tx_data | output | 8 | Outgoing reply byte |
| tx_valid | output | 1 | tx_data holds a byte |
| tx_ready | input | 1 | Receiver takes the byte this cycle |
| led_red | output | 1 | Last line was rejected |
| led_green | output | 1 | Last line was accepted |

## Verification
A corrupted parser state shows up at the end of the line. A wrong keyword or field flag gives the wrong reply text, and a wrong accumulator gives a wrong stored value. That stored value only becomes visible on the next read line, so each store is paired with a fetch. A wrong reply-generator state shows up within one reply: missing, extra or leading-zero digits, non-printable bytes, or bytes changing while the receiver stalls. A wrong handshake state is visible in the same cycle as rx_ready staying high during a reply.

// File: rtl/ascii_ram_pkg.sv
package ascii_ram_pkg;

    typedef enum logic [1:0] {KW_NONE, KW_WRITE, KW_READ} kw_e;
    typedef enum logic [1:0] {REP_OK, REP_BAD, REP_VAL} rep_e;
    typedef enum logic [2:0] {PS_KEY, PS_ADDR, PS_DATA, PS_EXEC, PS_START, PS_WAIT} pst_e;
    typedef enum logic [2:0] {RS_IDLE, RS_TEXT, RS_DIG, RS_CR, RS_LF} rst_e;

    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_LF    = 8'h0A;
    localparam logic [7:0] CH_COLON = 8'h3A;
    localparam logic [7:0] CH_COMMA = 8'h2C;

    function automatic logic [7:0] to_lower(input logic [7:0] b);
        return (b >= 8'h41 && b <= 8'h5A) ? (b | 8'h20) : b;
    endfunction

    function automatic logic is_digit(input logic [7:0] b);
        return (b >= 8'h30 && b <= 8'h39);
    endfunction

endpackage

// File: rtl/word_ram.sv
module word_ram #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata_q <= mem[addr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/cmd_parser.sv
module cmd_parser
    import ascii_ram_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    rx_data,
    input  logic          rx_valid,
    output logic          rx_ready,
    input  logic          busy,
    output logic          exec,
    output logic          start,
    output logic          is_wr,
    output logic          err,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data,
    output logic          led_red,
    output logic          led_green
);
    localparam logic [DW+3:0] VMAX = (DW+4)'((1 << DW) - 1);
    localparam logic [DW-1:0] AMAX = DW'((1 << AW) - 1);

    typedef struct packed {
        pst_e          st;
        logic [39:0]   kw;
        logic [2:0]    kwn;
        kw_e           kind;
        logic          bad;
        logic [DW-1:0] num;
        logic          num_ovf;
        logic          num_any;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          err;
        logic          wr;
        logic          red;
        logic          green;
    } pst_t;

    pst_t q, d;
    logic [DW+3:0] acc;
    logic          fire;
    logic          num_bad;

    always_comb begin
        d       = q;
        fire    = rx_valid && rx_ready;
        acc     = ({4'b0, q.num} << 3) + ({4'b0, q.num} << 1) + {{DW{1'b0}}, rx_data[3:0]};
        num_bad = !q.num_any || q.num_ovf || (q.num > AMAX);
        unique case (q.st)
            PS_KEY: if (fire) begin
                if (rx_data == CH_LF) begin
                    d.err = 1'b1;
                    d.wr  = 1'b0;
                    d.st  = PS_EXEC;
                end else if (rx_data == CH_COLON) begin
                    if (q.kwn == 3'd5 && q.kw == "write")          d.kind = KW_WRITE;
                    else if (q.kwn == 3'd4 && q.kw[31:0] == "read") d.kind = KW_READ;
                    else                                            d.kind = KW_NONE;
                    d.st = PS_ADDR;
                end else if (rx_data != CH_CR) begin
                    d.kw = {q.kw[31:0], to_lower(rx_data)};
                    if (q.kwn < 3'd6) d.kwn = q.kwn + 3'd1;
                end
            end
            PS_ADDR, PS_DATA: if (fire) begin
                if (is_digit(rx_data)) begin
                    d.num_any = 1'b1;
                    if (q.num_ovf || acc > VMAX) d.num_ovf = 1'b1;
                    else                         d.num = acc[DW-1:0];
                end else if (rx_data == CH_COMMA) begin
                    if (q.st == PS_ADDR && q.kind == KW_WRITE) begin
                        d.bad     = q.bad || num_bad;
                        d.addr    = q.num[AW-1:0];
                        d.num     = '0;
                        d.num_ovf = 1'b0;
                        d.num_any = 1'b0;
                        d.st      = PS_DATA;
                    end else begin
                        d.bad = 1'b1;
                    end
                end else if (rx_data == CH_LF) begin
                    d.st = PS_EXEC;
                    if (q.st == PS_ADDR) begin
                        d.wr   = 1'b0;
                        d.addr = q.num[AW-1:0];
                        d.err  = q.bad || num_bad || (q.kind != KW_READ);
                    end else begin
                        d.wr   = 1'b1;
                        d.data = q.num;
                        d.err  = q.bad || !q.num_any || q.num_ovf;
                    end
                end else if (rx_data != CH_CR) begin
                    d.bad = 1'b1;
                end
            end
            PS_EXEC: begin
                d.red   = q.err;
                d.green = !q.err;
                d.st    = PS_START;
            end
            PS_START: d.st = PS_WAIT;
            PS_WAIT: if (!busy) begin
                d.st      = PS_KEY;
                d.kw      = '0;
                d.kwn     = '0;
                d.kind    = KW_NONE;
                d.bad     = 1'b0;
                d.num     = '0;
                d.num_ovf = 1'b0;
                d.num_any = 1'b0;
            end
            default: d.st = PS_KEY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: PS_KEY, kind: KW_NONE, default: '0};
        else        q <= d;
    end

    assign rx_ready  = (q.st == PS_KEY) || (q.st == PS_ADDR) || (q.st == PS_DATA);
    assign exec      = (q.st == PS_EXEC);
    assign start     = (q.st == PS_START);
    assign is_wr     = q.wr;
    assign err       = q.err;
    assign addr      = q.addr;
    assign data      = q.data;
    assign led_red   = q.red;
    assign led_green = q.green;
endmodule

// File: rtl/reply_gen.sv
module reply_gen
    import ascii_ram_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  rep_e          kind,
    input  logic [DW-1:0] value,
    input  logic          tx_ready,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          busy
);
    function automatic int digits_for(input int w);
        longint m = (longint'(1) << w) - 1;
        int n = 1;
        while (m >= 10) begin
            m = m / 10;
            n++;
        end
        return n;
    endfunction

    localparam int NDIG = digits_for(DW);
    localparam int PW   = (NDIG > 1) ? $clog2(NDIG) : 1;

    localparam logic [39:0] TXT_OK  = "WR OK";
    localparam logic [95:0] TXT_BAD = "Bad Command!";
    localparam logic [39:0] TXT_VAL = "DATA=";

    function automatic logic [DW-1:0] pow10(input int k);
        longint r = 1;
        for (int i = 0; i < k; i++) r = r * 10;
        return DW'(r);
    endfunction

    function automatic logic [3:0] msg_len(input rep_e k);
        return (k == REP_BAD) ? 4'd12 : 4'd5;
    endfunction

    function automatic logic [7:0] msg_char(input rep_e k, input logic [3:0] i);
        unique case (k)
            REP_BAD: return TXT_BAD[8*(11 - int'(i)) +: 8];
            REP_VAL: return TXT_VAL[8*(4 - int'(i)) +: 8];
            default: return TXT_OK[8*(4 - int'(i)) +: 8];
        endcase
    endfunction

    typedef struct packed {
        rst_e          st;
        rep_e          kind;
        logic [3:0]    idx;
        logic [DW-1:0] rem;
        logic [PW-1:0] pos;
        logic [3:0]    dig;
        logic          started;
        logic          tv;
        logic [7:0]    td;
    } rst_t;

    rst_t q, d;
    logic can;
    logic [DW-1:0] pw;

    always_comb begin
        d   = q;
        can = !q.tv;
        pw  = pow10(int'(q.pos));
        if (q.tv && tx_ready) d.tv = 1'b0;
        unique case (q.st)
            RS_IDLE: if (start) begin
                d.kind    = kind;
                d.rem     = value;
                d.idx     = '0;
                d.pos     = PW'(NDIG - 1);
                d.dig     = '0;
                d.started = 1'b0;
                d.st      = RS_TEXT;
            end
            RS_TEXT: if (can) begin
                d.tv = 1'b1;
                d.td = msg_char(q.kind, q.idx);
                if (q.idx == msg_len(q.kind) - 4'd1) d.st = (q.kind == REP_VAL) ? RS_DIG : RS_CR;
                else                                  d.idx = q.idx + 4'd1;
            end
            RS_DIG: begin
                if (q.rem >= pw) begin
                    d.rem = q.rem - pw;
                    d.dig = q.dig + 4'd1;
                end else if (can) begin
                    if (q.dig != 4'd0 || q.started || q.pos == '0) begin
                        d.tv      = 1'b1;
                        d.td      = 8'h30 + {4'h0, q.dig};
                        d.started = 1'b1;
                    end
                    d.dig = '0;
                    if (q.pos == '0) d.st = RS_CR;
                    else             d.pos = q.pos - PW'(1);
                end
            end
            RS_CR: if (can) begin
                d.tv = 1'b1;
                d.td = CH_CR;
                d.st = RS_LF;
            end
            RS_LF: if (can) begin
                d.tv = 1'b1;
                d.td = CH_LF;
                d.st = RS_IDLE;
            end
            default: d.st = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: RS_IDLE, kind: REP_OK, default: '0};
        else        q <= d;
    end

    assign tx_valid = q.tv;
    assign tx_data  = q.td;
    assign busy     = (q.st != RS_IDLE) || q.tv;
endmodule

// File: rtl/ascii_ram_cmd.sv
module ascii_ram_cmd
    import ascii_ram_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] rx_data,
    input  logic       rx_valid,
    output logic       rx_ready,
    output logic [7:0] tx_data,
    output logic       tx_valid,
    input  logic       tx_ready,
    output logic       led_red,
    output logic       led_green
);
    logic          busy, exec, start, is_wr, err;
    logic [AW-1:0] addr;
    logic [DW-1:0] data, rdata;
    rep_e          kind;

    cmd_parser #(.AW(AW), .DW(DW)) u_parse (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .busy(busy), .exec(exec), .start(start),
        .is_wr(is_wr), .err(err), .addr(addr), .data(data),
        .led_red(led_red), .led_green(led_green)
    );

    word_ram #(.AW(AW), .DW(DW)) u_mem (
        .clk(clk), .we(exec && !err && is_wr), .re(exec && !err && !is_wr),
        .addr(addr), .wdata(data), .rdata(rdata)
    );

    assign kind = err ? REP_BAD : (is_wr ? REP_OK : REP_VAL);

    reply_gen #(.DW(DW)) u_reply (
        .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .value(rdata),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .busy(busy)
    );
endmodule

// File: rtl/ascii_ram_cmd_chk.sv
module ascii_ram_cmd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_ready,
    input logic [7:0] tx_data,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       led_red,
    input logic       led_green
);
    p_led_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(led_red && led_green));

    p_led_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && $past(rx_ready)) |-> ($stable(led_red) && $stable(led_green)));

    p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    p_rx_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !rx_ready);

    p_tx_chars_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> ((tx_data >= 8'h20 && tx_data <= 8'h7E) || tx_data == 8'h0D || tx_data == 8'h0A));
endmodule

bind ascii_ram_cmd ascii_ram_cmd_chk u_chk (.*);

// File: tb/tb_ascii_ram_cmd.sv
module tb_ascii_ram_cmd;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_valid = 1'b0;
    logic       rx_ready;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b0;
    logic       led_red, led_green;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    ascii_ram_cmd dut (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .led_red(led_red), .led_green(led_green)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string act, input string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    task automatic send_byte(input byte b);
        bit ok;
        rx_data  = b;
        rx_valid = 1'b1;
        for (int i = 0; i < 1000; i++) begin
            ok = rx_ready;
            @(negedge clk);
            if (ok) break;
        end
        rx_valid = 1'b0;
    endtask

    task automatic get_reply(output string r, output bit leaked);
        r = "";
        leaked = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            tx_ready = (i % 3) != 1;
            if (tx_valid && rx_ready) leaked = 1'b1;
            if (tx_valid && tx_ready) begin
                r = $sformatf("%s%c", r, tx_data);
                if (tx_data == 8'h0A) begin
                    @(negedge clk);
                    break;
                end
            end
            @(negedge clk);
        end
        tx_ready = 1'b0;
    endtask

    task automatic run(input string line, input string exp, input bit exp_err, input string req);
        string r;
        bit leaked;
        for (int i = 0; i < line.len(); i++) send_byte(line[i]);
        chk(rx_ready == 1'b0, {req, " R9 input held after LF"}, $sformatf("%0b", rx_ready), "0");
        get_reply(r, leaked);
        chk(r == exp, {req, " reply to ", line}, r, exp);
        chk(!leaked, {req, " R9 rx_ready low during reply"}, $sformatf("%0b", leaked), "0");
        for (int i = 0; i < 50 && !rx_ready; i++) @(negedge clk);
        chk(led_red == exp_err && led_green == !exp_err, {req, " R7 status outputs"},
            $sformatf("red=%0b green=%0b", led_red, led_green),
            $sformatf("red=%0b green=%0b", exp_err, !exp_err));
    endtask

    localparam string OK  = "WR OK\r\n";
    localparam string BAD = "Bad Command!\r\n";

    task automatic t_reset_r10();
        chk(!led_red && !led_green, "R10 leds after reset", $sformatf("%0b%0b", led_red, led_green), "00");
        chk(!tx_valid && rx_ready, "R10 handshake after reset", $sformatf("tv=%0b rr=%0b", tx_valid, rx_ready), "tv=0 rr=1");
    endtask

    task automatic t_basic_r1_r2();
        run("write:3,00042\r\n", OK, 0, "R1");
        run("read:003\r\n", "DATA=42\r\n", 0, "R2");
        run("write:255,65535\r\n", OK, 0, "R1 max");
        run("read:255\r\n", "DATA=65535\r\n", 0, "R2 max");
        run("write:7,0\r\n", OK, 0, "R1 zero");
        run("read:7\r\n", "DATA=0\r\n", 0, "R2 zero");
        run("write:8,1005\r\n", OK, 0, "R1 inner zeros");
        run("read:8\r\n", "DATA=1005\r\n", 0, "R2 inner zeros");
    endtask

    task automatic t_case_r3();
        run("WrItE:10,500\r\n", OK, 0, "R3");
        run("READ:10\r\n", "DATA=500\r\n", 0, "R3");
    endtask

    task automatic t_addr_range_r4();
        run("write:0,111\r\n", OK, 0, "R4 setup");
        run("write:256,5\r\n", BAD, 1, "R4");
        run("read:256\r\n", BAD, 1, "R4");
        run("read:0\r\n", "DATA=111\r\n", 0, "R4 no alias");
    endtask

    task automatic t_data_range_r5();
        run("write:1,222\r\n", OK, 0, "R5 setup");
        run("write:1,65536\r\n", BAD, 1, "R5");
        run("write:1,99999999999999999999\r\n", BAD, 1, "R5 long");
        run("read:1\r\n", "DATA=222\r\n", 0, "R5 unchanged");
    endtask

    task automatic t_comma_r6();
        run("write:5\r\n", BAD, 1, "R6 missing comma");
        run("read:5,1\r\n", BAD, 1, "R6 extra comma");
    endtask

    task automatic t_errors_r7();
        run("erase:1\r\n", BAD, 1, "R7 keyword");
        run("read:\r\n", BAD, 1, "R7 empty addr");
        run("write:2,\r\n", BAD, 1, "R7 empty value");
        run("read:1x\r\n", BAD, 1, "R7 non-digit");
        run("hello\r\n", BAD, 1, "R7 no colon");
        run("read:1\r\n", "DATA=222\r\n", 0, "R7 recovery");
    endtask

    task automatic t_line_end_r8();
        run("write:\r20,\r9\n", OK, 0, "R8 stray CR");
        run("read:20\n", "DATA=9\r\n", 0, "R8 bare LF");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r10();
        t_basic_r1_r2();
        t_case_r3();
        t_addr_range_r4();
        t_data_range_r5();
        t_comma_r6();
        t_errors_r7();
        t_line_end_r8();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule